// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a shared single-wire interrupt bus. The wire is open-drain, pulled high, and clocked by the bus clock. Each agent may drive the wire low, drive it high, or release it. The controller models the wire as three signals: a drive enable, a drive value and the sampled wire level. It opens each polling cycle with a start frame. It then counts fixed-length data frames and samples the wire in the first clock of each one. It turns those samples into a vector of request levels, applying the correct polarity to each line. Last, it closes the cycle with a stop frame whose length tells the peripherals which start mode comes next.

There are two start modes. In continuous mode the host alone opens every cycle, after a short idle gap. In quiet mode the wire stays released until a peripheral pulls it low. The host then takes over and drives low for one clock fewer than it would in continuous mode. Software selects the mode and the start-frame width through plain control pins. A mode request takes effect only at the next stop frame.

The request vector is a registered level, not a stream. It needs no handshake and has no back-pressure: a consumer samples it whenever it likes, and it changes at most once per polling cycle.

Top module: `sirq_host`

## Requirements
- R1: After reset the wire is released. The first cycle after `enable` rises is always a continuous one. A continuous start frame drives the wire low for W clocks: W is 4, 6 or 8 for `width_sel` 0, 1 or 2, and 8 for `width_sel` 3. The value of `width_sel` is taken at the edge where the start frame begins.
- R2: Every clock in which the host drives low is followed either by another low clock or by exactly one clock driven high. Every clock driven high is followed by a released clock.
- R3: After the start frame's high clock and one released clock come 21 data frames of three clocks each. The host releases the wire throughout the data frames. It samples the wire in the first clock of each frame.
- R4: Bit k of `irq_req` belongs to data frame k, counting from 0. For bits 0 to 15 the bit equals the sampled level. For bits 16 to 20 the bit equals the inverted sample.
- R5: `irq_req` changes only at the clock edge that ends the third clock of the last data frame. It resets to all zeros.
- R6: The stop frame drives the wire low for 2 clocks when `quiet_req` is 1 at the edge that begins the stop frame, and for 3 clocks otherwise. One high clock and one released clock follow.
- R7: In continuous mode the wire is released for GAP_CLKS clocks (default 2) after the stop frame. The next start frame then begins, unless `enable` is 0 at the edge that ends the gap.
- R8: In quiet mode the wire stays released until `sirq_in` is sampled low. The host then drives low for W-1 clocks, starting on the next clock, and the rest of the cycle follows as in R3 and R6.
- R9: A low `enable` is acted on only in the gap or in the quiet wait, never inside a cycle that has already begun. It leaves the wire released and keeps `irq_req` unchanged. The next enable starts a continuous cycle.
- R10: `quiet_mode` takes the value of `quiet_req` at the edge that begins the stop frame. It clears at the edge where a low `enable` ends a quiet wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the polling engine |
| quiet_req | input | 1 | Requests quiet mode from the next stop frame |
| width_sel | input | 2 | Start-frame width code |
| sirq_in | input | 1 | Sampled level of the shared wire |
| sirq_oe | output | 1 | Host drives the wire when 1 |
| sirq_out | output | 1 | Level driven when `sirq_oe` is 1 |
| irq_req | output | 21 | Request levels, one bit per data frame |
| quiet_mode | output | 1 | Stop frame selected quiet mode |

## Verification
The drive signals follow one register stage after the edge that decides them. A quiet start therefore appears one clock after the low sample. The stop length is fixed at the edge that leaves the last data frame. The request vector moves at that same edge and is visible during the first stop clock. The bench's reference model advances at each rising edge using only values the bench set earlier. The bench compares drive, vector and mode at every falling edge, so each result is checked in the clock where it is due. The peripheral stimulus is placed in a frame's sample clock using the model's own frame count, never the design's.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [3:0] {
    S_OFF, S_SLOW, S_SREC, S_STA, S_DSMP, S_DREC, S_DTA,
    S_PLOW, S_PREC, S_PTA, S_GAP, S_WAIT
  } sirq_state_e;

  // start-frame low length for a width code (R1)
  function automatic logic [3:0] sirq_start_clocks(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd4;
      2'd1:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int NFRAMES  = 21,
  parameter int GAP_CLKS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       quiet_req,
  input  logic [1:0]                 width_sel,
  input  logic                       line_in,
  output logic                       drv_en,
  output logic                       drv_val,
  output logic                       smp_stb,
  output logic [$clog2(NFRAMES)-1:0] frame_idx,
  output logic                       frame_done,
  output logic                       quiet_mode
);
  localparam int FW = $clog2(NFRAMES);
  localparam int CW = $clog2(GAP_CLKS + 9) + 1;
  localparam logic [FW-1:0] LAST = FW'(NFRAMES - 1);

  sirq_state_e   st;
  logic [CW-1:0] cnt;
  logic [FW-1:0] fidx;
  logic          mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      cnt    <= '0;
      fidx   <= '0;
      mode_q <= 1'b0;
    end else begin
      case (st)
        S_OFF: if (enable) begin
          st  <= S_SLOW;
          cnt <= CW'(sirq_start_clocks(width_sel));
        end
        S_SLOW: if (cnt == CW'(1)) st <= S_SREC; else cnt <= cnt - CW'(1);
        S_SREC: st <= S_STA;
        S_STA: begin
          st   <= S_DSMP;
          fidx <= '0;
        end
        S_DSMP: st <= S_DREC;
        S_DREC: st <= S_DTA;
        S_DTA: if (fidx == LAST) begin
          st     <= S_PLOW;
          mode_q <= quiet_req;
          cnt    <= quiet_req ? CW'(2) : CW'(3);
        end else begin
          st   <= S_DSMP;
          fidx <= fidx + FW'(1);
        end
        S_PLOW: if (cnt == CW'(1)) st <= S_PREC; else cnt <= cnt - CW'(1);
        S_PREC: st <= S_PTA;
        S_PTA: begin
          st  <= mode_q ? S_WAIT : S_GAP;
          cnt <= CW'(GAP_CLKS);
        end
        S_GAP: if (cnt == CW'(1)) begin
          if (enable) begin
            st  <= S_SLOW;
            cnt <= CW'(sirq_start_clocks(width_sel));
          end else begin
            st <= S_OFF;
          end
        end else begin
          cnt <= cnt - CW'(1);
        end
        S_WAIT: if (!enable) begin
          st     <= S_OFF;
          mode_q <= 1'b0;
        end else if (!line_in) begin
          st  <= S_SLOW;
          cnt <= CW'(sirq_start_clocks(width_sel) - 4'd1);
        end
        default: st <= S_OFF;
      endcase
    end
  end

  always_comb begin
    drv_en  = 1'b0;
    drv_val = 1'b1;
    case (st)
      S_SLOW, S_PLOW: begin drv_en = 1'b1; drv_val = 1'b0; end
      S_SREC, S_PREC: drv_en = 1'b1;
      default: ;
    endcase
  end

  assign smp_stb    = (st == S_DSMP);
  assign frame_idx  = fidx;
  assign frame_done = (st == S_DTA) && (fidx == LAST);
  assign quiet_mode = mode_q;

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture #(
  parameter int NUM_HIGH = 16,
  parameter int NFRAMES  = 21
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_stb,
  input  logic [$clog2(NFRAMES)-1:0] frame_idx,
  input  logic                       line_in,
  input  logic                       frame_done,
  output logic [NFRAMES-1:0]         irq_req
);
  logic [NFRAMES-1:0] samp;
  logic [NFRAMES-1:0] lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp <= '0;
    else if (smp_stb) samp[frame_idx] <= line_in;
  end

  // R4: per-line polarity
  for (genvar i = 0; i < NFRAMES; i++) begin : g_pol
    if (i < NUM_HIGH) begin : g_hi
      assign lvl[i] = samp[i];
    end else begin : g_lo
      assign lvl[i] = ~samp[i];
    end
  end

  // R5: one update per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= '0;
    else if (frame_done) irq_req <= lvl;
  end

endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
  parameter int NUM_HIGH  = 16,
  parameter int NUM_LOWAC = 5,
  parameter int GAP_CLKS  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            enable,
  input  logic                            quiet_req,
  input  logic [1:0]                      width_sel,
  input  logic                            sirq_in,
  output logic                            sirq_oe,
  output logic                            sirq_out,
  output logic [NUM_HIGH+NUM_LOWAC-1:0]   irq_req,
  output logic                            quiet_mode
);
  localparam int NFRAMES = NUM_HIGH + NUM_LOWAC;
  localparam int FW      = $clog2(NFRAMES);

  logic          smp_stb;
  logic          frame_done;
  logic [FW-1:0] frame_idx;

  sirq_seq #(.NFRAMES(NFRAMES), .GAP_CLKS(GAP_CLKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .quiet_req  (quiet_req),
    .width_sel  (width_sel),
    .line_in    (sirq_in),
    .drv_en     (sirq_oe),
    .drv_val    (sirq_out),
    .smp_stb    (smp_stb),
    .frame_idx  (frame_idx),
    .frame_done (frame_done),
    .quiet_mode (quiet_mode)
  );

  sirq_capture #(.NUM_HIGH(NUM_HIGH), .NFRAMES(NFRAMES)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_stb    (smp_stb),
    .frame_idx  (frame_idx),
    .line_in    (sirq_in),
    .frame_done (frame_done),
    .irq_req    (irq_req)
  );

endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
  parameter int NFRAMES = 21
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sirq_oe,
  input logic                       sirq_out,
  input logic                       smp_stb,
  input logic                       frame_done,
  input logic [$clog2(NFRAMES)-1:0] frame_idx,
  input logic [NFRAMES-1:0]         irq_req,
  input logic                       quiet_mode
);

  assert_low_then_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && !sirq_out) |=> sirq_oe);

  assert_high_then_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && sirq_out) |=> !sirq_oe);

  assert_data_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> !sirq_oe);

  assert_frame_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (int'(frame_idx) < NFRAMES));

  assert_vector_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(irq_req));

  assert_quiet_at_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quiet_mode) |-> (sirq_oe && !sirq_out));

endmodule

bind sirq_host sirq_host_chk #(.NFRAMES(NFRAMES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sirq_oe    (sirq_oe),
  .sirq_out   (sirq_out),
  .smp_stb    (smp_stb),
  .frame_done (frame_done),
  .frame_idx  (frame_idx),
  .irq_req    (irq_req),
  .quiet_mode (quiet_mode)
);

// File: tb/tb_sirq_host.sv
module tb_sirq_host;
  localparam int NF = 21;
  localparam int NISA = 16;
  localparam int GAP = 2;
  localparam int DATA_CLKS = 3 * NF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic quiet_req = 1'b0;
  logic [1:0] width_sel = 2'd0;
  logic sirq_in, sirq_oe, sirq_out, quiet_mode;
  logic [NF-1:0] irq_req;

  logic periph_low = 1'b0;
  logic line_hold = 1'b1;
  logic kick = 1'b0;
  logic [NF-1:0] pat = '1;
  bit go = 0;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  assign sirq_in = ((sirq_oe && !sirq_out) || periph_low) ? 1'b0 : 1'b1;

  sirq_host dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .quiet_req(quiet_req),
    .width_sel(width_sel), .sirq_in(sirq_in), .sirq_oe(sirq_oe),
    .sirq_out(sirq_out), .irq_req(irq_req), .quiet_mode(quiet_mode)
  );

  always #4 clk = ~clk;

  // ---------------- reference model: 0 off, 1 run, 2 gap, 3 wait
  int m_st = 0, m_t = 0, m_L = 4, m_SL = 3, m_g = 0, m_d = 0;
  bit m_q = 0, m_qstart = 0;
  logic [NF-1:0] m_samp = '0, m_irq = '0;

  function automatic int wsel(logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 6 : 8;   // R1
  endfunction

  always @(posedge clk) begin
    go = 1;
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_L = 4; m_SL = 3; m_g = 0; m_q = 0;
      m_samp = '0; m_irq = '0;
    end else begin
      case (m_st)
        0: if (enable) begin m_st = 1; m_t = 0; m_L = wsel(width_sel); m_qstart = 0; end
        1: begin
          m_d = m_t - (m_L + 2);
          if (m_d >= 0 && m_d < DATA_CLKS && m_d % 3 == 0) m_samp[m_d/3] = line_hold;
          if (m_d == DATA_CLKS - 1) begin
            for (int i = 0; i < NF; i++) m_irq[i] = (i < NISA) ? m_samp[i] : !m_samp[i];
            m_SL = quiet_req ? 2 : 3;
            m_q = quiet_req;
          end
          if (m_t == m_L + 2 + DATA_CLKS + m_SL + 1) begin
            if (m_q) m_st = 3;
            else begin m_st = 2; m_g = GAP; end
          end else m_t++;
        end
        2: begin
          m_g--;
          if (m_g == 0) begin
            if (enable) begin m_st = 1; m_t = 0; m_L = wsel(width_sel); m_qstart = 0; end
            else m_st = 0;
          end
        end
        default: if (!enable) begin m_st = 0; m_q = 0; end
                 else if (!line_hold) begin
                   m_st = 1; m_t = 0; m_L = wsel(width_sel) - 1; m_qstart = 1;
                 end
      endcase
    end
  end

  // peripheral: drives sample clocks per pattern, or starts a quiet cycle
  always @(negedge clk) begin
    int d;
    d = m_t - (m_L + 2);
    periph_low = (m_st == 1 && d >= 0 && d < DATA_CLKS && d % 3 == 0 && !pat[d/3]) ||
                 (m_st == 3 && kick);
    #1 line_hold = sirq_in;
  end

  // ---------------- per-cycle comparison
  always @(negedge clk) begin
    bit e_oe, e_val;
    int s0;
    string tag;
    if (go) begin
      e_oe = 0; e_val = 1; tag = "R9";
      if (m_st == 2) tag = "R7";
      if (m_st == 3) tag = "R8";
      if (m_st == 1) begin
        s0 = m_L + 2 + DATA_CLKS;
        tag = "R3";
        if (m_t < m_L) begin e_oe = 1; e_val = 0; tag = m_qstart ? "R8" : "R1"; end
        else if (m_t == m_L) begin e_oe = 1; tag = "R2"; end
        else if (m_t >= s0 && m_t < s0 + m_SL) begin e_oe = 1; e_val = 0; tag = "R6"; end
        else if (m_t == s0 + m_SL) begin e_oe = 1; tag = "R2"; end
      end
      n_cmp++;
      if (sirq_oe !== e_oe || (e_oe && sirq_out !== e_val)) begin
        n_bad++;
        $display("FAIL %s t=%0d drive oe/out=%b/%b expected %b/%b", tag, cyc, sirq_oe, sirq_out, e_oe, e_val);
      end
      n_cmp++;   // R4 R5 vector content and timing
      if (irq_req !== m_irq) begin
        n_bad++;
        $display("FAIL R4 R5 t=%0d irq_req=%h expected %h", cyc, irq_req, m_irq);
      end
      n_cmp++;   // R10
      if (quiet_mode !== m_q) begin
        n_bad++;
        $display("FAIL R10 t=%0d quiet_mode=%b expected %b", cyc, quiet_mode, m_q);
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL watchdog t=%0d expected run to end", cyc);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_state(int s);
    for (int k = 0; k < 400 && m_st != s; k++) step(1);
  endtask

  initial begin
    step(3);                                       // reset state held
    rst_n = 1'b1;
    step(4);                                       // R9 released while disabled
    enable = 1'b1; width_sel = 2'd0; pat = 21'h0A5F3C;   // R1 first cycle continuous
    step(90);
    width_sel = 2'd1; pat = 21'h1F0001;            // R4 R7
    step(170);
    width_sel = 2'd2; pat = '0;
    step(90);
    width_sel = 2'd3; pat = '1;                    // R1 code 3
    quiet_req = 1'b1;                              // R6 R10 short stop
    wait_state(3);
    step(12);                                      // R8 idle wait
    pat = 21'h15A0F3; width_sel = 2'd1;
    kick = 1'b1; step(1); kick = 1'b0;             // R8 quiet start
    wait_state(3);
    quiet_req = 1'b0; width_sel = 2'd0; pat = 21'h0F0F0F;
    kick = 1'b1; step(1); kick = 1'b0;
    wait_state(1);
    step(20);
    enable = 1'b0;                                 // R9 ignored mid-cycle
    wait_state(0);
    step(6);
    enable = 1'b1; quiet_req = 1'b1; pat = 21'h100000;
    wait_state(3);
    step(3);
    enable = 1'b0;                                 // R9 R10 leave quiet wait
    step(5);
    enable = 1'b1; quiet_req = 1'b0;
    step(100);
    finish_run();
  end

endmodule